// File: doc/BRIEF.md
# Vector Doubleword Multiply-Sum Unit

This unit takes three 128-bit vector operands, A, B and C. Each operand is split into two unsigned 64-bit doublewords. Doubleword 0 is the upper 64 bits and doubleword 1 is the lower 64 bits. The unit forms the two full 128-bit products A.dw0×B.dw0 and A.dw1×B.dw1, and adds both products to C.

A mode bit selects what the unit returns:
- **Wrap mode** returns the 128-bit sum, discarding anything above bit 127.
- **Carry mode** returns only the carry that leaves bit 127 of that sum.

The carry is built from two partial sums. The low doubleword terms are added first, and their carry is folded into the sum of the high doubleword terms.

A small decoder reads a 32-bit instruction word and checks three things: the encoding, a newer-feature-level input, and a unit-enable input. If the word is well formed, the operation is accepted. Otherwise the unit pulses an illegal-instruction flag or a unit-unavailable flag. An accepted operation runs a bit-serial multiply over `DW` cycles and then presents its result with a one-cycle `done` pulse.

Top module: `vmsum_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `unavail` and `result` are all zero.
- R2: In wrap mode, `result` = (C + A.dw0·B.dw0 + A.dw1·B.dw1) mod 2^128, where doubleword 0 is bits 127:64 of an operand and doubleword 1 is bits 63:0.
- R3: In carry mode, `result[1:0]` holds the carry out of bit 127 of the same three-term sum, and bits 127:2 are zero.
- R4: The carry value never exceeds 2. With A, B and C all ones, carry mode returns exactly 2.
- R5: An instruction is recognised when bits 31:26 equal 4. Its extended code in bits 5:0 then selects the mode: 35 selects wrap mode and 23 selects carry mode. Bits 25:6 have no effect. Every other word gives a one-cycle `illegal` pulse and no `done`.
- R6: The carry-mode code is illegal when `feat_new` is 0. The wrap-mode code is accepted whatever the value of `feat_new`.
- R7: A recognised, legal word issued while `unit_en` is 0 gives a one-cycle `unavail` pulse and no `done`. An illegal word gives `illegal` and not `unavail`, even when `unit_en` is 0.
- R8: `done` is high for exactly one cycle. It rises DW+1 clock edges after the edge that sampled the accepted `start`. `busy` is high from the edge after acceptance until `done` rises.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the operation in flight, and it produces no extra `done`, `illegal` or `unavail`.
- R10: `illegal` and `unavail` rise on the edge that samples `start` and last one cycle.
- R11: `result` keeps its value after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue request, sampled when idle |
| instr | input | 32 | Instruction word to decode |
| feat_new | input | 1 | Newer feature level present (permits carry mode) |
| unit_en | input | 1 | Vector unit enabled |
| opa | input | 2*DW | Operand A |
| opb | input | 2*DW | Operand B |
| opc | input | 2*DW | Addend C |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 2*DW | Wrap sum or carry value |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| unavail | output | 1 | One-cycle unit-unavailable pulse |

## Verification
The hardest case to reach is a carry of exactly 2. It occurs only when the high partial sum overflows twice, and that needs both products close to 2^128 while C is also large. Random operands almost never produce it. The vector table therefore forces it with all-ones operands, and it also holds neighbouring cases that give a carry of 1 from a single overflow, either in the low half or in the high half. A second situation that needs care is a `start` arriving mid-run. The bench raises it part-way through a multiply with different operands and an illegal word, then checks that the first result survives and that nothing further pulses.

// File: rtl/vmsum_pkg.sv
package vmsum_pkg;
   typedef enum logic {
      SUM_WRAP  = 1'b0,
      SUM_CARRY = 1'b1
   } sum_mode_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_FIN  = 2'd2
   } seq_state_e;

   localparam logic [5:0] PRIMARY_VEC = 6'd4;
   localparam logic [5:0] XCODE_WRAP  = 6'd35;
   localparam logic [5:0] XCODE_CARRY = 6'd23;
endpackage

// File: rtl/vmsum_decode.sv
module vmsum_decode
   import vmsum_pkg::*;
(
   input  logic [5:0] primary_i,
   input  logic [5:0] xcode_i,
   input  logic       feat_i,
   input  logic       en_i,
   output logic       ok_o,
   output logic       illegal_o,
   output logic       unavail_o,
   output sum_mode_e  mode_o
);
   logic is_vec, hit_wrap, hit_carry, known;

   always_comb begin
      is_vec    = (primary_i == PRIMARY_VEC);
      hit_wrap  = is_vec && (xcode_i == XCODE_WRAP);
      hit_carry = is_vec && (xcode_i == XCODE_CARRY);
      known     = hit_wrap || (hit_carry && feat_i);
      illegal_o = !known;
      unavail_o = known && !en_i;
      ok_o      = known && en_i;
      mode_o    = hit_carry ? SUM_CARRY : SUM_WRAP;
   end
endmodule

// File: rtl/vmsum_lane.sv
module vmsum_lane #(
   parameter int DW = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   output logic [2*DW-1:0] prod_o
);
   localparam int PW = 2 * DW;

   logic [PW-1:0] acc_q, mcand_q;
   logic [DW-1:0] mplier_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
      end else if (load_i) begin
         acc_q    <= '0;
         mcand_q  <= {{DW{1'b0}}, a_i};
         mplier_q <= b_i;
      end else if (step_i) begin
         if (mplier_q[0]) acc_q <= acc_q + mcand_q;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
      end
   end

   assign prod_o = acc_q;
endmodule

// File: rtl/vmsum_combine.sv
module vmsum_combine
   import vmsum_pkg::*;
#(
   parameter int DW = 64
) (
   input  sum_mode_e       mode_i,
   input  logic [2*DW-1:0] c_i,
   input  logic [2*DW-1:0] p0_i,
   input  logic [2*DW-1:0] p1_i,
   output logic [2*DW-1:0] res_o
);
   localparam int VW = 2 * DW;
   localparam int HW = DW + 2;

   logic [VW-1:0] wrap_sum;
   logic [HW-1:0] low_part, high_part;

   always_comb begin
      wrap_sum  = c_i + p0_i + p1_i;
      low_part  = {2'b00, c_i[DW-1:0]} + {2'b00, p0_i[DW-1:0]}
                + {2'b00, p1_i[DW-1:0]};
      high_part = {2'b00, c_i[VW-1:DW]} + {2'b00, p0_i[VW-1:DW]}
                + {2'b00, p1_i[VW-1:DW]} + {{DW{1'b0}}, low_part[HW-1:DW]};
      if (mode_i == SUM_CARRY) res_o = {{(VW-2){1'b0}}, high_part[HW-1:DW]};
      else                     res_o = wrap_sum;
   end
endmodule

// File: rtl/vmsum_unit.sv
module vmsum_unit
   import vmsum_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [31:0]     instr,
   input  logic            feat_new,
   input  logic            unit_en,
   input  logic [2*DW-1:0] opa,
   input  logic [2*DW-1:0] opb,
   input  logic [2*DW-1:0] opc,
   output logic            busy,
   output logic            done,
   output logic [2*DW-1:0] result,
   output logic            illegal,
   output logic            unavail
);
   localparam int VW    = 2 * DW;
   localparam int LANES = 2;
   localparam int CW    = $clog2(DW);

   if (DW < 2) begin : g_bad_width
      $error("vmsum_unit: DW must be at least 2");
   end

   seq_state_e     state_q;
   logic [CW-1:0]  step_q;
   sum_mode_e      mode_q, dec_mode;
   logic [VW-1:0]  c_q, comb_res, result_q;
   logic [VW-1:0]  prod [LANES];
   logic           dec_ok, dec_illegal, dec_unavail;
   logic           idle, accept, stepping;
   logic           done_q, illegal_q, unavail_q;

   vmsum_decode dec_i (
      .primary_i (instr[31:26]),
      .xcode_i   (instr[5:0]),
      .feat_i    (feat_new),
      .en_i      (unit_en),
      .ok_o      (dec_ok),
      .illegal_o (dec_illegal),
      .unavail_o (dec_unavail),
      .mode_o    (dec_mode)
   );

   assign idle     = (state_q == SEQ_IDLE);
   assign accept   = start && idle && dec_ok;
   assign stepping = (state_q == SEQ_RUN);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      vmsum_lane #(.DW(DW)) lane_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (accept),
         .step_i (stepping),
         .a_i    (opa[VW-1-g*DW -: DW]),
         .b_i    (opb[VW-1-g*DW -: DW]),
         .prod_o (prod[g])
      );
   end

   vmsum_combine #(.DW(DW)) comb_i (
      .mode_i (mode_q),
      .c_i    (c_q),
      .p0_i   (prod[0]),
      .p1_i   (prod[1]),
      .res_o  (comb_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         step_q    <= '0;
         mode_q    <= SUM_WRAP;
         c_q       <= '0;
         result_q  <= '0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         unavail_q <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         illegal_q <= start && idle && dec_illegal;
         unavail_q <= start && idle && dec_unavail;
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  mode_q  <= dec_mode;
                  c_q     <= opc;
                  step_q  <= '0;
                  state_q <= SEQ_RUN;
               end
            end
            SEQ_RUN: begin
               step_q <= step_q + 1'b1;
               if (step_q == CW'(DW - 1)) state_q <= SEQ_FIN;
            end
            SEQ_FIN: begin
               result_q <= comb_res;
               done_q   <= 1'b1;
               state_q  <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy    = !idle;
   assign done    = done_q;
   assign result  = result_q;
   assign illegal = illegal_q;
   assign unavail = unavail_q;
endmodule

// File: rtl/vmsum_unit_chk.sv
module vmsum_unit_chk
   import vmsum_pkg::*;
#(
   parameter int DW = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            illegal,
   input logic            unavail,
   input logic [2*DW-1:0] result,
   input sum_mode_e       mode_q
);
   localparam int VW = 2 * DW;
   localparam int LW = $clog2(DW + 3) + 1;

   logic [LW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_q <= '0;
      else if (busy) lat_q <= lat_q + 1'b1;
      else           lat_q <= '0;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R8
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(DW + 1)));                                    // R8
   AST_CARRY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q == SUM_CARRY) |-> (result[VW-1:2] == '0));           // R3
   AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, illegal, unavail}));                                 // R7
   AST_BUSY_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (!illegal && !unavail));                         // R9
   AST_EXC_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal || unavail) |-> !busy);                                     // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(busy)) |-> $stable(result));                        // R11
endmodule

bind vmsum_unit vmsum_unit_chk #(.DW(DW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .illegal (illegal),
   .unavail (unavail),
   .result  (result),
   .mode_q  (mode_q)
);

// File: tb/vmsum_unit_tb_top.sv
module vmsum_unit_tb_top;
   localparam int DW = 64;
   localparam int VW = 2 * DW;
   localparam int NV = 8;

   // {carry_mode, A, B, C, expected}
   localparam logic [4*VW:0] VEC [NV] = '{
      {1'b0, 128'h0, 128'h0, 128'h0, 128'h0},
      {1'b0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}},
             128'hFFFFFFFFFFFFFFFC_0000000000000001},
      {1'b1, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 128'd2},
      {1'b1, 128'h0, 128'h0, 128'h0, 128'h0},
      {1'b0, {64'd3, 64'd5}, {64'd7, 64'd11}, 128'd24, 128'd100},
      {1'b1, {128{1'b1}}, {128{1'b1}}, 128'h0, 128'd1},
      {1'b1, {64'd1, 64'd0}, {64'd1, 64'd0}, {128{1'b1}}, 128'd1},
      {1'b0, {64'd1, 64'd0}, {64'd1, 64'd0}, {128{1'b1}}, 128'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   instr = '0;
   logic          feat_new = 1'b1;
   logic          unit_en = 1'b1;
   logic [VW-1:0] opa = '0, opb = '0, opc = '0;
   logic          busy, done, illegal, unavail;
   logic [VW-1:0] result;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   vmsum_unit #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .feat_new(feat_new), .unit_en(unit_en), .opa(opa), .opb(opb),
      .opc(opc), .busy(busy), .done(done), .result(result),
      .illegal(illegal), .unavail(unavail)
   );

   function automatic logic [31:0] mk_word(input logic [5:0] prim,
                                           input logic [5:0] xo);
      return {prim, 5'd1, 5'd2, 5'd3, 5'd4, xo};
   endfunction

   function automatic logic [VW-1:0] ref_model(input logic [VW-1:0] a, b, c,
                                               input bit carry);
      logic [VW+1:0] p0, p1, tot;
      p0  = (VW+2)'(a[VW-1:DW]) * (VW+2)'(b[VW-1:DW]);
      p1  = (VW+2)'(a[DW-1:0])  * (VW+2)'(b[DW-1:0]);
      tot = (VW+2)'(c) + p0 + p1;
      return carry ? VW'(tot[VW+1:VW]) : tot[VW-1:0];
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issues one request; returns edges to done, and pulses seen after start.
   task automatic issue(input logic [31:0] w, input logic [VW-1:0] a, b, c,
                        output int lat, output bit ill, output bit unav);
      @(negedge clk);
      instr = w; opa = a; opb = b; opc = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ill  = illegal;
      unav = unavail;
      lat  = 0;
      while (!done && lat < DW + 5) begin
         @(negedge clk);
         lat++;
         if (illegal || unavail) begin ill = 1'b1; unav = 1'b1; end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int lat;
      bit ill, unav;
      logic [VW-1:0] a, b, c, exp, held;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !illegal && !unavail && result == '0, "R1",
            {busy, done, illegal, unavail}, '0);
      rst_n = 1'b1;

      // Table walk: R2, R3, R4, R8
      for (int i = 0; i < NV; i++) begin
         a = VEC[i][4*VW-1:3*VW]; b = VEC[i][3*VW-1:2*VW];
         c = VEC[i][2*VW-1:VW];   exp = VEC[i][VW-1:0];
         issue(mk_word(6'd4, VEC[i][4*VW] ? 6'd23 : 6'd35), a, b, c, lat, ill, unav);
         check(result == exp, VEC[i][4*VW] ? "R3/R4 carry table" : "R2 wrap table", result, exp);
         check(lat == DW + 1, "R8 latency", VW'(lat), VW'(DW + 1));
         @(negedge clk);
         check(!done, "R8 single-cycle done", VW'(done), '0);
      end

      // Random vectors, both modes: R2, R3
      for (int i = 0; i < 24; i++) begin
         bit cm;
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         c = {$urandom, $urandom, $urandom, $urandom};
         if (i % 4 == 3) begin a = ~(a & 128'hFF); b = ~(b & 128'hF0F); end
         cm  = i[0];
         exp = ref_model(a, b, c, cm);
         issue(mk_word(6'd4, cm ? 6'd23 : 6'd35), a, b, c, lat, ill, unav);
         check(result == exp, cm ? "R3 carry random" : "R2 wrap random", result, exp);
         if (cm) check(result <= 2, "R4 carry bound", result, 128'd2);
      end

      // R11: result held after done
      held = result;
      repeat (4) @(negedge clk);
      check(result == held, "R11 result held", result, held);

      // R5: register fields ignored
      a = {64'd9, 64'd2}; b = {64'd4, 64'd8}; c = 128'd1;
      issue({6'd4, 20'hABCDE, 6'd35}, a, b, c, lat, ill, unav);
      check(result == 128'd53 && lat == DW + 1, "R5 field bits ignored", result, 128'd53);
      // R5, R10: bad primary opcode
      issue(mk_word(6'd5, 6'd35), a, b, c, lat, ill, unav);
      check(ill && lat == DW + 5, "R5/R10 bad primary illegal", VW'({ill, lat}), '0);
      @(negedge clk);
      check(!illegal, "R10 illegal one cycle", VW'(illegal), '0);
      // R5: bad extended code
      issue(mk_word(6'd4, 6'd36), a, b, c, lat, ill, unav);
      check(ill && lat == DW + 5, "R5 bad extended code illegal", VW'(lat), VW'(DW + 5));

      // R6: feature gate
      feat_new = 1'b0;
      issue(mk_word(6'd4, 6'd23), a, b, c, lat, ill, unav);
      check(ill && !unav && lat == DW + 5, "R6 carry gated", VW'({ill, unav}), VW'(2));
      issue(mk_word(6'd4, 6'd35), a, b, c, lat, ill, unav);
      check(!ill && lat == DW + 1 && result == 128'd53, "R6 wrap unaffected", result, 128'd53);
      feat_new = 1'b1;

      // R7: unit disabled
      unit_en = 1'b0;
      issue(mk_word(6'd4, 6'd35), a, b, c, lat, ill, unav);
      check(unav && !ill && lat == DW + 5, "R7 unavailable", VW'({ill, unav}), VW'(1));
      @(negedge clk);
      check(!unavail, "R10 unavail one cycle", VW'(unavail), '0);
      issue(mk_word(6'd7, 6'd35), a, b, c, lat, ill, unav);
      check(ill && !unav, "R7 illegal precedence", VW'({ill, unav}), VW'(2));
      unit_en = 1'b1;

      // R9: starts while busy are ignored
      @(negedge clk);
      instr = mk_word(6'd4, 6'd35); opa = {64'd2, 64'd3}; opb = {64'd5, 64'd7};
      opc = 128'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check(busy, "R8 busy during run", VW'(busy), VW'(1));
      instr = mk_word(6'd4, 6'd23); opa = '1; opb = '1; opc = '1; start = 1'b1;
      @(negedge clk);
      instr = mk_word(6'd9, 6'd1);
      @(negedge clk);
      start = 1'b0;
      check(!illegal && !unavail, "R9 no pulse from ignored start",
            VW'({illegal, unavail}), '0);
      lat = 0;
      while (!done && lat < DW + 5) begin @(negedge clk); lat++; end
      check(result == 128'd31, "R9 first op result kept", result, 128'd31);
      lat = 0;
      for (int k = 0; k < DW + 4; k++) begin
         @(negedge clk);
         if (done || illegal || unavail) lat++;
      end
      check(lat == 0, "R9 no extra completion", VW'(lat), '0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule